// File: doc/BRIEF.md
# Sorted-Table Binary Search Engine

This block looks up a 32-bit key in an ascending table that sits in a synchronous-read memory outside the block. A one-cycle `start` pulse loads the key. The engine then narrows an index window `[low, high]`, which begins as the whole table. For each probe it takes the floor midpoint, sends it to the memory with a one-cycle read enable, and waits for the registered read data to come back. It then compares the returned word with the key and moves one bound of the window.

The search ends in one of two ways. If a probed word equals the key, the engine reports a hit at that index. If the window empties, it reports a miss. When the search ends, `done` is high for one cycle. At the same time `match` and the signed `location` take their new values, and they keep those values until the next search ends. The default table has 3872 words with a 12-bit index. The table must be sorted in ascending order with the words treated as unsigned; otherwise the result has no meaning.

Top module: `bsearch_engine`

## Requirements
- R1: While synchronous reset is held, the outputs are `busy`=0, `done`=0, `match`=0, `location`=-1 (all ones, 13-bit two's complement) and `mem_rd_en`=0.
- R2: When `start` is high in idle, `target` is captured at that clock edge and the window is set to low=0, high=DEPTH-1. `busy` is high from the next cycle until the result cycle.
- R3: A `start` pulse seen while `busy` or `done` is high is ignored. The search in flight finishes with the result for its own key.
- R4: Each probe presents `mem_addr` = floor((low+high)/2) with `mem_rd_en` high for exactly one cycle. The first probe of every search is at index 1935.
- R5: The word compared is the read data one cycle after `mem_rd_en`, taken at the current probe address. Data from an earlier address is never used.
- R6: A word below the key sets low = mid+1; a word above the key sets high = mid-1. Both cases go back to the window check before the next probe.
- R7: A word equal to the key ends the search. `done` is high for one cycle with `match`=1 and `location`=mid.
- R8: When low > high at the window check, the search ends with `done` for one cycle, `match`=0 and `location`=-1.
- R9: A key below the smallest word drives high to -1 after a probe at index 0. The search ends as a miss and high never wraps to a large value.
- R10: Each probe takes 5 cycles: window check, midpoint, read issue, read wait, compare. After the start edge, `done` appears in cycle 5k+1 for a hit on probe k and in cycle 5k+2 for a miss after k probes. This is never later than cycle 62.
- R11: `match` and `location` change only in the cycle where `done` is high, and they hold between searches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search with `target` (idle only) |
| target | input | 32 | Key to look up |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| match | output | 1 | Last search found the key |
| location | output | 13 | Signed index of the hit, -1 on a miss |
| mem_rd_en | output | 1 | Table read enable |
| mem_addr | output | 12 | Table read index |
| mem_rdata | input | 32 | Registered table read data, one cycle after `mem_rd_en` |

## Verification
The table is filled with 10+7*i, so every key in between is missing from it. The keys tried are the middle word, which hits on the first probe, and the first and last words, which sit at the deepest left and right paths. A word at an interior index and two absent keys that fall between table words are also tried. A key below the minimum exercises the underflow of high at index 0, and a key above the maximum drives low past the top index. Each run is followed probe by probe against a behavioural search that gives the expected read address, read cycle and result cycle. This exposes a stale-data compare, a wrong bound update and a miscounted wait state. One run also sends a second `start` with a different key in the middle of the search, which shows whether the busy engine refuses to restart.

// File: rtl/bsearch_pkg.sv
// Package: shared types of the binary search engine.
// Assumes nothing beyond IEEE 1800-2017.
package bsearch_pkg;

    // Controller states; one probe walks CHECK -> MID -> ISSUE -> WAIT -> CMP.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_MID,
        ST_ISSUE,
        ST_WAIT,
        ST_CMP,
        ST_FOUND,
        ST_MISS
    } bs_state_e;

endpackage

// File: rtl/bsearch_bounds.sv
// Module: bsearch_bounds
// Holds the signed search window [low, high] and the registered midpoint.
// Assumes: the controller loads the midpoint only after a passing window
// check, so low+high is non-negative there. The bounds carry two more bits
// than the index, which lets high reach -1 and low reach DEPTH without wrapping.
module bsearch_bounds #(
    parameter int DEPTH  = 3872,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              mid_load,
    input  logic              go_up,
    input  logic              go_down,
    output logic              range_ok,
    output logic [ADDR_W-1:0] mid
);
    localparam int IW = ADDR_W + 2;
    localparam logic signed [IW-1:0] HI_INIT = IW'(DEPTH - 1);
    localparam logic signed [IW-1:0] ONE     = IW'(1);
    localparam logic signed [IW-1:0] NEG1    = '1;

    logic signed [IW-1:0] low_q, high_q, sum, mid_ext;
    logic [ADDR_W-1:0]    mid_q;

    assign sum      = low_q + high_q;
    assign mid_ext  = $signed({{(IW-ADDR_W){1'b0}}, mid_q});
    assign range_ok = (low_q <= high_q);
    assign mid      = mid_q;

    // Window bounds: reset or restart to the full table, else move one bound.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            low_q  <= '0;
            high_q <= HI_INIT;
        end else if (go_up) begin
            low_q  <= mid_ext + ONE;
        end else if (go_down) begin
            high_q <= mid_ext - ONE;
        end
    end

    // Midpoint register: floor of the window's centre.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q <= '0;
        end else if (mid_load) begin
            mid_q <= ADDR_W'(sum >>> 1);
        end
    end

    // R4: the loaded midpoint lies inside the window it was taken from.
    p_mid_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mid_load |=> (mid_ext >= $past(low_q)) && (mid_ext <= $past(high_q)));

    // R9: high may go down to -1 but never below, and never wraps.
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (high_q >= NEG1) && (high_q <= HI_INIT));
endmodule

// File: rtl/bsearch_cmp.sv
// Module: bsearch_cmp
// Captures the search key and the word read for the current probe, and
// compares the two as unsigned values.
// Assumes: cap_data is raised in the cycle where the memory output holds the
// word for the current probe address.
module bsearch_cmp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_key,
    input  logic [DATA_W-1:0] key_in,
    input  logic              cap_data,
    input  logic [DATA_W-1:0] rdata,
    output logic              less,
    output logic              greater
);
    logic [DATA_W-1:0] key_q, word_q;

    // Key register: loaded only on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)       key_q <= '0;
        else if (cap_key) key_q <= key_in;
    end

    // Probe word register: holds the read result for the compare state.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= '0;
        else if (cap_data) word_q <= rdata;
    end

    assign less    = (word_q < key_q);
    assign greater = (word_q > key_q);
endmodule

// File: rtl/bsearch_ctrl.sv
// Module: bsearch_ctrl
// Sequences the probes of one search and owns the result registers.
// Assumes: the memory returns data one cycle after a read enable, and the
// bounds and compare blocks respond on the edge after their strobes.
module bsearch_ctrl
    import bsearch_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PROBES = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                range_ok,
    input  logic                less,
    input  logic                greater,
    input  logic [ADDR_W-1:0]   mid,
    output logic                init,
    output logic                mid_load,
    output logic                go_up,
    output logic                go_down,
    output logic                cap_key,
    output logic                cap_data,
    output logic                rd_en,
    output logic                busy,
    output logic                done,
    output logic                match,
    output logic signed [ADDR_W:0] location
);
    localparam int MAX_BUSY = 5 * PROBES;
    localparam int CW       = $clog2(MAX_BUSY + 2) + 1;

    bs_state_e state_q, state_d;

    // Next-state and strobe decode: every compare outcome names its next state.
    always_comb begin
        state_d  = state_q;
        init     = 1'b0;
        cap_key  = 1'b0;
        mid_load = 1'b0;
        rd_en    = 1'b0;
        cap_data = 1'b0;
        go_up    = 1'b0;
        go_down  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    init    = 1'b1;
                    cap_key = 1'b1;
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: state_d = range_ok ? ST_MID : ST_MISS;
            ST_MID: begin
                mid_load = 1'b1;
                state_d  = ST_ISSUE;
            end
            ST_ISSUE: begin
                rd_en   = 1'b1;
                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                cap_data = 1'b1;
                state_d  = ST_CMP;
            end
            ST_CMP: begin
                if (less) begin
                    go_up   = 1'b1;
                    state_d = ST_CHECK;
                end else if (greater) begin
                    go_down = 1'b1;
                    state_d = ST_CHECK;
                end else begin
                    state_d = ST_FOUND;
                end
            end
            ST_FOUND: state_d = ST_IDLE;
            ST_MISS:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result registers: written only on entry to a terminal state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match    <= 1'b0;
            location <= '1;
        end else if (state_q == ST_CMP && !less && !greater) begin
            match    <= 1'b1;
            location <= $signed({1'b0, mid});
        end else if (state_q == ST_CHECK && !range_ok) begin
            match    <= 1'b0;
            location <= '1;
        end
    end

    assign busy = (state_q != ST_IDLE) && (state_q != ST_FOUND) && (state_q != ST_MISS);
    assign done = (state_q == ST_FOUND) || (state_q == ST_MISS);

    // Busy-cycle counter used only to bound the search length.
    logic [CW-1:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    // R7: the result strobe lasts one cycle.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: each read enable is a single-cycle pulse.
    p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    // R3: a busy engine only continues or finishes; a start cannot reset it.
    p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R10: no search stays busy longer than PROBES probes plus a final check.
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt <= CW'(MAX_BUSY)));
endmodule

// File: rtl/bsearch_engine.sv
// Module: bsearch_engine (top)
// Binary search of an ascending table held in an external memory with
// registered reads of one cycle latency.
// Assumes: the table is sorted in ascending unsigned order and the memory
// returns mem_rdata one cycle after mem_rd_en for the address given then.
module bsearch_engine #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 3872,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [DATA_W-1:0]      target,
    output logic                   busy,
    output logic                   done,
    output logic                   match,
    output logic signed [ADDR_W:0] location,
    output logic                   mem_rd_en,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic [DATA_W-1:0]      mem_rdata
);
    localparam int PROBES = $clog2(DEPTH + 1);

    logic init, mid_load, go_up, go_down, cap_key, cap_data;
    logic range_ok, less, greater;
    logic [ADDR_W-1:0] mid;

    bsearch_bounds #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bounds (
        .clk(clk), .rst_n(rst_n), .init(init), .mid_load(mid_load),
        .go_up(go_up), .go_down(go_down), .range_ok(range_ok), .mid(mid)
    );

    bsearch_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cap_key(cap_key), .key_in(target),
        .cap_data(cap_data), .rdata(mem_rdata), .less(less), .greater(greater)
    );

    bsearch_ctrl #(.ADDR_W(ADDR_W), .PROBES(PROBES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .range_ok(range_ok),
        .less(less), .greater(greater), .mid(mid), .init(init),
        .mid_load(mid_load), .go_up(go_up), .go_down(go_down),
        .cap_key(cap_key), .cap_data(cap_data), .rd_en(mem_rd_en),
        .busy(busy), .done(done), .match(match), .location(location)
    );

    assign mem_addr = mid;

    // R5: the probe word is captured exactly one cycle after its read enable.
    p_capture_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_data |-> $past(mem_rd_en));

    // R11: the reported location changes only together with the strobe.
    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(location) |-> done);

    // R2: the key is frozen while a search is running.
    p_key_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(u_cmp.key_q));
endmodule

// File: tb/bsearch_engine_tb.sv
// Bench for bsearch_engine: a behavioural search gives the expected probe
// schedule, and the outputs are compared against it on every clock.
module bsearch_engine_tb;
    localparam int DEPTH = 3872;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [31:0]        target = '0;
    logic               busy, done, match, mem_rd_en;
    logic signed [12:0] location;
    logic [11:0]        mem_addr;
    logic [31:0]        mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    bsearch_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .target(target),
        .busy(busy), .done(done), .match(match), .location(location),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    // Table contents are computed: ascending with gaps of 7.
    function automatic logic [31:0] tbl(input int idx);
        return 32'(10 + 7 * idx);
    endfunction

    // Memory model: registered read with one cycle of latency.
    always @(posedge clk) if (mem_rd_en) mem_rdata <= tbl(int'(mem_addr));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One search with a per-cycle comparison; inj>0 pulses start with key2 then.
    task automatic run_search(input logic [31:0] key, input int inj, input logic [31:0] key2);
        int probes[$];
        int lo = 0, hi = DEPTH - 1, k = 0, exp_loc = -1, n_done;
        bit hit = 0;
        while (lo <= hi) begin
            int m = (lo + hi) / 2;
            probes.push_back(m);
            k++;
            if (tbl(m) < key)      lo = m + 1;
            else if (tbl(m) > key) hi = m - 1;
            else begin hit = 1; exp_loc = m; break; end
        end
        n_done = hit ? 5 * k + 1 : 5 * k + 2;
        chk(n_done <= 62, "R10 bound", n_done, 62);
        chk(probes[0] == 1935, "R4 first probe", probes[0], 1935);

        @(negedge clk); start = 1'b1; target = key;
        @(negedge clk); start = 1'b0;
        for (int c = 1; c <= n_done + 2; c++) begin
            bit exp_rd = 0;
            int exp_addr = 0;
            for (int j = 0; j < probes.size(); j++)
                if (c == 5 * j + 3) begin exp_rd = 1; exp_addr = probes[j]; end
            chk(busy == (c < n_done), "R2 busy", int'(busy), int'(c < n_done));
            chk(done == (c == n_done), "R10 done cycle", int'(done), int'(c == n_done));
            chk(mem_rd_en == exp_rd, "R4 read enable", int'(mem_rd_en), int'(exp_rd));
            if (exp_rd) chk(int'(mem_addr) == exp_addr, "R6 probe address", int'(mem_addr), exp_addr);
            if (c >= n_done) begin
                chk(match == hit, hit ? "R7 match" : "R8 match", int'(match), int'(hit));
                chk(int'(location) == exp_loc, hit ? "R5 R7 location" : "R8 location",
                    int'(location), exp_loc);
            end
            if (c > n_done) chk(int'(location) == exp_loc, "R11 hold", int'(location), exp_loc);
            if (inj > 0 && c == inj) begin start = 1'b1; target = key2; end
            else start = 1'b0;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(!busy, "R1 busy", int'(busy), 0);
        chk(!done, "R1 done", int'(done), 0);
        chk(!match, "R1 match", int'(match), 0);
        chk(int'(location) == -1, "R1 location", int'(location), -1);
        chk(!mem_rd_en, "R1 read enable", int'(mem_rd_en), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_search(tbl(1935), 0, '0);        // R7 middle, one probe
        run_search(tbl(0), 0, '0);           // R7 first word, left path
        run_search(tbl(DEPTH - 1), 0, '0);   // R7 last word, right path
        run_search(tbl(100), 0, '0);         // R6 interior word
        run_search(32'd11, 0, '0);           // R8 absent between words
        run_search(tbl(2000) + 3, 0, '0);    // R8 absent interior
        run_search(32'd0, 0, '0);            // R9 below minimum, high -> -1
        run_search(32'd40000, 0, '0);        // R8 above maximum, low -> DEPTH
        run_search(tbl(500), 7, tbl(3000));  // R3 start ignored while busy
        run_search(tbl(3000), 0, '0);        // R3 engine restarts cleanly after

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule